// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a minimal processor core that completes one whole instruction in every clock cycle. A program counter selects a 32-bit word from an internal instruction array. The word is decoded into one of three layouts: register, immediate or jump. Five operations are executed: register addition, register bitwise OR, a signed byte load from an internal byte-addressed data array, an equality branch relative to the program counter, and an absolute jump within the current 256 MB region. Any other encoding leaves every register unchanged and moves on to the next word.

The two arrays are filled through simple write ports while reset is held. Reset is synchronous and clears the program counter and all 32 registers. A combinational debug port returns the contents of any register, so a test environment can follow the state of the program without stopping the core.

Top module: `scyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. The first instruction after reset is fetched from word 0.
- R2: Opcode bits [31:26] = 6'b000000 with funct bits [5:0] = 6'b100000 writes rs + rt, modulo 2^32, into register rd. The fields are rs = [25:21], rt = [20:16], rd = [15:11], and shamt = [10:6], which is ignored.
- R3: Opcode 6'b000000 with funct 6'b100101 writes rs | rt into register rd.
- R4: Opcode 6'b100000 writes into rt the byte at data address rs + sign-extended [15:0], sign-extended to 32 bits. The address is taken modulo `DMEM_BYTES`.
- R5: Opcode 6'b000100 compares registers rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended [15:0] << 2). When they differ, the next PC is PC + 4.
- R6: Opcode 6'b000010 sets the next PC to {(PC+4)[31:28], [25:0], 2'b00}.
- R7: Register 0 always reads as 0, and a write that targets it has no effect.
- R8: Any other opcode, or opcode 6'b000000 with any other funct, writes no register and advances the PC by 4.
- R9: Without a jump or a taken branch, the PC advances by 4 on every clock edge, and each instruction's register write is visible after the edge that ends its cycle.
- R10: `dbgData` shows the current contents of the register selected by `dbgSel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imemWe | input | 1 | Instruction array write strobe |
| imemAddr | input | $clog2(IMEM_WORDS) | Instruction word index to write |
| imemData | input | 32 | Instruction word to write |
| dmemWe | input | 1 | Data array write strobe |
| dmemAddr | input | $clog2(DMEM_BYTES) | Byte address to write |
| dmemData | input | 8 | Byte to write |
| dbgSel | input | 5 | Register to observe |
| dbgData | output | 32 | Contents of the selected register |

## Verification
The hardest situations to reach from the ports are the control-flow cases. Examples are a taken branch that skips over loads that would otherwise write registers, and a jump that lands on a non-sequential word. None of these shows up directly at an output. The stimulus is therefore a single program: every skipped word is a load into a register that would otherwise stay at zero, and the program ends in a backward branch that targets itself. The final register image then proves which words ran. Register values are also sampled cycle by cycle right after reset, to pin down the single-cycle timing and the restart from word 0.

// File: rtl/scyc_pkg.sv
package scyc_pkg;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_JMP  = 6'b000010;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_LDB  = 6'b100000;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_OR   = 6'b100101;

  // Strobes from control to datapath
  typedef struct packed {
    logic regWrite;   // commit a result to the register file
    logic destIsRd;   // destination field: rd (1) or rt (0)
    logic fromMem;    // result comes from the loaded byte
    logic aluOr;      // ALU does OR instead of ADD
    logic branch;     // equality branch
    logic jump;       // absolute jump
  } ctrl_t;

endpackage

// File: rtl/scyc_ctrl.sv
module scyc_ctrl
  import scyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  logic isRegAdd, isRegOr, known;

  always_comb begin
    isRegAdd = (opcode == OP_REG) && (funct == FN_ADD);
    isRegOr  = (opcode == OP_REG) && (funct == FN_OR);
    known    = isRegAdd || isRegOr || (opcode == OP_LDB) ||
               (opcode == OP_BEQ) || (opcode == OP_JMP);
  end

  always_comb begin
    ctrl = '0;
    unique case (1'b1)
      isRegAdd: begin
        ctrl.regWrite = 1'b1;
        ctrl.destIsRd = 1'b1;
      end
      isRegOr: begin
        ctrl.regWrite = 1'b1;
        ctrl.destIsRd = 1'b1;
        ctrl.aluOr    = 1'b1;
      end
      (opcode == OP_LDB): begin
        ctrl.regWrite = 1'b1;
        ctrl.fromMem  = 1'b1;
      end
      (opcode == OP_BEQ): ctrl.branch = 1'b1;
      (opcode == OP_JMP): ctrl.jump   = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // R8: encodings outside the subset produce no strobe at all
  a_r8_unknown_idle: assert property (@(posedge clk) disable iff (rst)
    !known |-> (ctrl == '0));

  // R5/R6: at most one kind of effect per instruction
  a_r6_one_effect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.regWrite, ctrl.branch, ctrl.jump}));

endmodule

// File: rtl/scyc_regfile.sv
module scyc_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned REGS = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(REGS)-1:0] rdIdxA,
  output logic [XLEN-1:0]         rdValA,
  input  logic [$clog2(REGS)-1:0] rdIdxB,
  output logic [XLEN-1:0]         rdValB,
  input  logic                    wrEn,
  input  logic [$clog2(REGS)-1:0] wrIdx,
  input  logic [XLEN-1:0]         wrVal,
  input  logic [$clog2(REGS)-1:0] dbgIdx,
  output logic [XLEN-1:0]         dbgVal
);

  logic [XLEN-1:0] regs [REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else if (wrEn && (wrIdx != '0)) begin
      regs[wrIdx] <= wrVal;
    end
  end

  always_comb begin
    rdValA = regs[rdIdxA];
    rdValB = regs[rdIdxB];
    dbgVal = regs[dbgIdx];
  end

  // R7: register 0 never holds anything but zero
  a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  // R2: an accepted write is visible on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx != '0) |=> (regs[$past(wrIdx)] == $past(wrVal)));

endmodule

// File: rtl/scyc_dpath.sv
module scyc_dpath
  import scyc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrl_t                         ctrl,
  output logic [5:0]                    opcode,
  output logic [5:0]                    funct,
  input  logic                          imemWe,
  input  logic [$clog2(IMEM_WORDS)-1:0] imemAddr,
  input  logic [31:0]                   imemData,
  input  logic                          dmemWe,
  input  logic [$clog2(DMEM_BYTES)-1:0] dmemAddr,
  input  logic [7:0]                    dmemData,
  input  logic [4:0]                    dbgSel,
  output logic [31:0]                   dbgData
);

  localparam int unsigned IAW = $clog2(IMEM_WORDS);
  localparam int unsigned DAW = $clog2(DMEM_BYTES);

  logic [31:0] imem [IMEM_WORDS];
  logic [7:0]  dmem [DMEM_BYTES];

  logic [31:0] pcReg, pcPlus4, brTarget, jmpTarget, pcNext;
  logic [31:0] instr, immSext, rsVal, rtVal, aluRes, memAddr, loadSext, wbVal;
  logic [4:0]  rsIdx, rtIdx, rdIdx, wbIdx;
  logic [7:0]  loadByte;
  logic        brTaken;
  logic        unusedBits;

  // Array write ports
  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
    if (dmemWe) dmem[dmemAddr] <= dmemData;
  end

  // Fetch and field split
  always_comb begin
    instr   = imem[pcReg[IAW+1:2]];
    opcode  = instr[31:26];
    rsIdx   = instr[25:21];
    rtIdx   = instr[20:16];
    rdIdx   = instr[15:11];
    funct   = instr[5:0];
    immSext = {{16{instr[15]}}, instr[15:0]};
  end

  assign unusedBits = ^{instr[10:6], memAddr[31:DAW], pcReg[1:0]};

  scyc_regfile #(.XLEN(32), .REGS(32)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .rdIdxA (rsIdx),
    .rdValA (rsVal),
    .rdIdxB (rtIdx),
    .rdValB (rtVal),
    .wrEn   (ctrl.regWrite),
    .wrIdx  (wbIdx),
    .wrVal  (wbVal),
    .dbgIdx (dbgSel),
    .dbgVal (dbgData)
  );

  // Execute and writeback selection
  always_comb begin
    aluRes   = ctrl.aluOr ? (rsVal | rtVal) : (rsVal + rtVal);
    memAddr  = rsVal + immSext;
    loadByte = dmem[memAddr[DAW-1:0]];
    loadSext = {{24{loadByte[7]}}, loadByte};
    wbVal    = ctrl.fromMem ? loadSext : aluRes;
    wbIdx    = ctrl.destIsRd ? rdIdx : rtIdx;
  end

  // Next program counter
  always_comb begin
    pcPlus4   = pcReg + 32'd4;
    brTarget  = pcPlus4 + {immSext[29:0], 2'b00};
    jmpTarget = {pcPlus4[31:28], instr[25:0], 2'b00};
    brTaken   = ctrl.branch && (rsVal == rtVal);
    if (ctrl.jump)   pcNext = jmpTarget;
    else if (brTaken) pcNext = brTarget;
    else             pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= pcNext;
  end

  // R9: sequential flow steps by one word
  a_r9_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !brTaken) |=> (pcReg == $past(pcReg) + 32'd4));

  // R6: jump keeps the region bits and installs the target field
  a_r6_jump_field: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pcReg[27:2] == $past(instr[25:0])) &&
                  (pcReg[31:28] == $past(pcPlus4[31:28])));

  // R5: a taken branch moves by the scaled offset
  a_r5_branch_move: assert property (@(posedge clk) disable iff (rst)
    brTaken |=> (pcReg == $past(pcReg) + 32'd4 + {$past(immSext[29:0]), 2'b00}));

  // R1: the program counter stays word aligned
  a_r1_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pcReg[1:0] == 2'b00);

endmodule

// File: rtl/scyc_core.sv
module scyc_core
  import scyc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imemWe,
  input  logic [$clog2(IMEM_WORDS)-1:0] imemAddr,
  input  logic [31:0]                   imemData,
  input  logic                          dmemWe,
  input  logic [$clog2(DMEM_BYTES)-1:0] dmemAddr,
  input  logic [7:0]                    dmemData,
  input  logic [4:0]                    dbgSel,
  output logic [31:0]                   dbgData
);

  ctrl_t      ctrl;
  logic [5:0] opcode;
  logic [5:0] funct;

  scyc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  scyc_dpath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_BYTES(DMEM_BYTES)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .funct    (funct),
    .imemWe   (imemWe),
    .imemAddr (imemAddr),
    .imemData (imemData),
    .dmemWe   (dmemWe),
    .dmemAddr (dmemAddr),
    .dmemData (dmemData),
    .dbgSel   (dbgSel),
    .dbgData  (dbgData)
  );

endmodule

// File: tb/scyc_core_bench.sv
`timescale 1ns/1ps
module scyc_core_bench;

  localparam int unsigned IW = 64;
  localparam int unsigned DB = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemWe = 1'b0;
  logic [5:0]  imemAddr = '0;
  logic [31:0] imemData = '0;
  logic        dmemWe = 1'b0;
  logic [7:0]  dmemAddr = '0;
  logic [7:0]  dmemData = '0;
  logic [4:0]  dbgSel = '0;
  logic [31:0] dbgData;

  int checks = 0;
  int errors = 0;
  int pending = 0;
  bit finished = 1'b0;

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  scyc_core #(.IMEM_WORDS(IW), .DMEM_BYTES(DB)) u_scyc_core (
    .clk(clk), .rst(rst),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .dmemWe(dmemWe), .dmemAddr(dmemAddr), .dmemData(dmemData),
    .dbgSel(dbgSel), .dbgData(dbgData)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] encJ(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  // Compare one register via the debug port (called at a negedge)
  task automatic compareReg(int idx, logic [31:0] val, string tag);
    dbgSel = 5'(idx);
    #1;
    checks++;
    if (dbgData !== val) begin
      errors++;
      $display("FAIL %s: r%0d actual %h expected %h", tag, idx, dbgData, val);
    end
  endtask

  // Driver side of the scoreboard
  task automatic expectReg(int idx, logic [31:0] val, string tag);
    exp_t e;
    e.idx = idx; e.val = val; e.tag = tag;
    pending++;
    expQ.push_back(e);
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      wait (expQ.size() > 0);
      @(negedge clk);
      begin
        exp_t e;
        e = expQ.pop_front();
        compareReg(e.idx, e.val, e.tag);
        pending--;
      end
    end
  end

  task automatic writeI(int a, logic [31:0] w);
    @(negedge clk);
    imemWe = 1'b1; imemAddr = 6'(a); imemData = w;
    @(negedge clk);
    imemWe = 1'b0;
  endtask
  task automatic writeD(int a, logic [7:0] b);
    @(negedge clk);
    dmemWe = 1'b1; dmemAddr = 8'(a); dmemData = b;
    @(negedge clk);
    dmemWe = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected program completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Fill instruction array with zero words, then the program
    for (int i = 0; i < IW; i++) writeI(i, 32'h0);
    writeI(0,  encI(6'b100000, 0, 1, 16'h0010));      // r1 = 0x41
    writeI(1,  encI(6'b100000, 0, 2, 16'h0011));      // r2 = sext 0x80
    writeI(2,  encI(6'b100000, 0, 5, 16'h0012));      // r5 = 0x0C
    writeI(3,  encR(1, 2, 3, 7, 6'b100000));          // add, shamt nonzero
    writeI(4,  encR(5, 1, 4, 0, 6'b100101));          // or
    writeI(5,  encR(3, 3, 6, 0, 6'b100000));          // add with wrap
    writeI(6,  encI(6'b100000, 1, 7, 16'hFFFF));      // load at r1-1
    writeI(7,  encR(1, 1, 0, 0, 6'b100000));          // write to r0
    writeI(8,  encI(6'b001000, 0, 10, 16'h0005));     // unsupported opcode
    writeI(9,  encR(1, 2, 11, 0, 6'b100010));         // unsupported funct
    writeI(10, encI(6'b000100, 1, 2, 16'h0002));      // beq not taken
    writeI(11, encI(6'b100000, 0, 12, 16'h0010));     // r12 = 0x41
    writeI(12, encI(6'b000100, 1, 12, 16'h0002));     // beq taken -> 15
    writeI(13, encI(6'b100000, 0, 13, 16'h0010));     // skipped
    writeI(14, encI(6'b100000, 0, 13, 16'h0011));     // skipped
    writeI(15, encJ(26'd20));                         // jump -> 20
    writeI(16, encI(6'b100000, 0, 14, 16'h0010));     // skipped
    writeI(20, encI(6'b100000, 0, 15, 16'h0012));     // r15 = 0x0C
    writeI(21, encJ(26'd23));                         // jump -> 23
    writeI(22, encI(6'b100000, 0, 16, 16'h0010));     // skipped
    writeI(23, encI(6'b000100, 0, 0, 16'hFFFF));      // branch to self
    writeD(8'h10, 8'h41);
    writeD(8'h11, 8'h80);
    writeD(8'h12, 8'h0C);
    writeD(8'h40, 8'h96);

    // R1: registers cleared under reset
    @(negedge clk);
    for (int r = 0; r < 32; r += 5) compareReg(r, 32'h0, "R1 reset clear");

    // Release reset; one instruction per edge (R9)
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    compareReg(1, 32'h0000_0041, "R9 first edge / R4 load");
    compareReg(2, 32'h0, "R9 second not yet");
    @(negedge clk);
    compareReg(2, 32'hFFFF_FF80, "R4 sign extend byte");
    repeat (40) @(negedge clk);

    expectReg(0,  32'h0,          "R7 r0 stays zero");
    expectReg(3,  32'hFFFF_FFC1,  "R2 add, shamt ignored");
    expectReg(4,  32'h0000_004D,  "R3 or");
    expectReg(5,  32'h0000_000C,  "R4 load positive");
    expectReg(6,  32'hFFFF_FF82,  "R2 add wraps");
    expectReg(7,  32'hFFFF_FF96,  "R4 negative offset");
    expectReg(10, 32'h0,          "R8 unsupported opcode");
    expectReg(11, 32'h0,          "R8 unsupported funct");
    expectReg(12, 32'h0000_0041,  "R5 not taken falls through");
    expectReg(13, 32'h0,          "R5 taken skips");
    expectReg(14, 32'h0,          "R6 jump skips");
    expectReg(15, 32'h0000_000C,  "R6 jump lands");
    expectReg(16, 32'h0,          "R6 second jump skips");
    expectReg(1,  32'h0000_0041,  "R10 debug read");
    wait (pending == 0);

    // Self loop holds: state unchanged later (R5 backward offset)
    repeat (10) @(negedge clk);
    expectReg(15, 32'h0000_000C, "R5 self loop stable");
    expectReg(16, 32'h0,         "R5 self loop stable");
    wait (pending == 0);

    // R1: second reset restarts from word 0
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    compareReg(3,  32'h0, "R1 re-reset clear");
    compareReg(15, 32'h0, "R1 re-reset clear");
    rst = 1'b0;
    @(negedge clk);
    compareReg(1, 32'h0000_0041, "R1 restart at word 0");
    compareReg(3, 32'h0, "R1 restart at word 0");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule